// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timing Generator

This block produces one complete 8-bit NAND flash bus cycle for each request it accepts. A request can be a command latch, an address latch, a data write or a data read. The host presents the request with a valid/ready handshake that carries the cycle kind and the data byte. The block then moves the flash strobes and latch lines through three phases: setup, strobe pulse and hold. The length of each phase comes from a packed 32-bit timing word.

The timing word has separate read and write halves. Each half has setup, hold and pulse fields, plus a ready-sample delay field. After the hold phase, the block waits for the programmed delay and then samples the flash ready pin once. It then signals completion for one clock and returns the sampled ready level. For a read, it also returns the byte captured from the data bus. A separate level input forces chip enable active. The block does not drive chip enable by itself.

Top module: `nand_cycle_gen`

## Requirements
- R1: While reset is applied, and in the first clock after it, the outputs are idle: req_ready_o=1, done_o=0, nand_we_n_o=1, nand_re_n_o=1, nand_cle_o=0, nand_ale_o=0, nand_dq_oe_o=0 and nand_ce_n_o=1.
- R2: A request is taken on a rising edge where req_valid_i and req_ready_o are both 1. req_kind_i is encoded 00 command, 01 address, 10 data write, 11 data read.
- R3: A field value n sets a phase to n+1 clocks. The setup phase follows acceptance and lasts n+1 clocks. A data read takes n from timing_i[3:0]. The other three kinds take n from timing_i[19:16]. The timing word is captured at acceptance.
- R4: The strobe is low for n+1 clocks. The strobe is nand_re_n_o for a read and nand_we_n_o otherwise. A read takes n from timing_i[11:8]; the others take it from timing_i[27:24]. Both strobes are never low together.
- R5: The hold phase follows the pulse and lasts n+1 clocks, with both strobes high. A read takes n from timing_i[7:4]; the others take it from timing_i[23:20].
- R6: From setup through hold, a command drives nand_cle_o=1 and nand_ale_o=0, an address drives nand_ale_o=1 and nand_cle_o=0, and data cycles drive both low. Outside a cycle, both are 0.
- R7: For non-read kinds, nand_dq_oe_o=1 and nand_dq_o equals the request byte from setup through hold. For a read, nand_dq_oe_o stays 0.
- R8: A read captures nand_dq_i at the rising edge that ends the last pulse clock. The captured byte is presented on rd_data_o.
- R9: After hold, the block waits 2*n clocks, then samples nand_rdy_i in one clock. A read takes n from timing_i[15:12]; the others take it from timing_i[31:28]. With n=0, the sample clock comes directly after hold. done_o pulses for the one clock after the sample, with done_rdy_o showing the sampled level.
- R10: nand_ce_n_o equals the inverse of ce_force_i, one clock later.
- R11: From acceptance until done_o rises, req_ready_o is 0, and a request held on the inputs changes neither the running cycle nor its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request will be taken |
| req_kind_i | input | 2 | Cycle kind (00 cmd, 01 addr, 10 write, 11 read) |
| req_data_i | input | 8 | Command, address or write byte |
| timing_i | input | 32 | Packed phase timing word |
| ce_force_i | input | 1 | Force chip enable active |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rdy_i | input | 1 | Flash ready pin |
| rd_data_o | output | 8 | Captured read byte |
| done_o | output | 1 | One-clock completion pulse |
| done_rdy_o | output | 1 | Sampled ready level |

## Verification
The bench counts, on every cycle, how many clocks the strobe stays high before it falls, how many it stays low, and how long the block takes to reach done_o. It compares each count with the n+1 and 2*n rules, using all-zero and all-fifteen fields and the read and write halves. A design that used the wrong half, or that was off by one clock, shows a count that differs by one or more.

The flash data bus carries the correct byte only during the final pulse clock, and the ready pin shows the expected level only during the intended sample clock. A capture or a sample taken one clock early or late therefore returns the inverted value. During each busy window, the bench holds a conflicting request on the inputs. A design that accepted it would change the latch lines or the bus byte, or would raise req_ready_o early.

// File: rtl/nand_cyc_pkg.sv
`timescale 1ns/1ps
package nand_cyc_pkg;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'b00,
        KIND_ADDR  = 2'b01,
        KIND_WDATA = 2'b10,
        KIND_RDATA = 2'b11
    } cyc_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_WAIT,
        PH_SAMPLE
    } phase_e;

    // Slot order inside one half of the timing word (decoded position).
    localparam int unsigned SLOT_SETUP  = 0;
    localparam int unsigned SLOT_HOLD   = 1;
    localparam int unsigned SLOT_WIDTH  = 2;
    localparam int unsigned SLOT_DELAY  = 3;
    localparam int unsigned SLOTS_HALF  = 4;
    localparam int unsigned SLOTS_TOTAL = 2 * SLOTS_HALF;

    function automatic logic kind_is_read(cyc_kind_e k);
        return k == KIND_RDATA;
    endfunction

    function automatic logic phase_active(phase_e p);
        return (p == PH_SETUP) || (p == PH_PULSE) || (p == PH_HOLD);
    endfunction

endpackage

// File: rtl/nand_timing_sel.sv
`timescale 1ns/1ps
module nand_timing_sel
    import nand_cyc_pkg::*;
#(
    parameter int unsigned FIELD_W  = 4,
    localparam int unsigned TIMING_W = SLOTS_TOTAL * FIELD_W
) (
    input  logic [TIMING_W-1:0] timing_i,
    input  logic                is_read_i,
    output logic [FIELD_W-1:0]  setup_o,
    output logic [FIELD_W-1:0]  width_o,
    output logic [FIELD_W-1:0]  hold_o,
    output logic [FIELD_W-1:0]  delay_o
);

    logic [FIELD_W-1:0] slot_q [SLOTS_TOTAL];

    for (genvar g = 0; g < SLOTS_TOTAL; g++) begin : g_slot
        assign slot_q[g] = timing_i[g*FIELD_W +: FIELD_W];
    end

    // Read half occupies the low slots, write half the high slots.
    always_comb begin
        if (is_read_i) begin
            setup_o = slot_q[SLOT_SETUP];
            width_o = slot_q[SLOT_WIDTH];
            hold_o  = slot_q[SLOT_HOLD];
            delay_o = slot_q[SLOT_DELAY];
        end else begin
            setup_o = slot_q[SLOTS_HALF + SLOT_SETUP];
            width_o = slot_q[SLOTS_HALF + SLOT_WIDTH];
            hold_o  = slot_q[SLOTS_HALF + SLOT_HOLD];
            delay_o = slot_q[SLOTS_HALF + SLOT_DELAY];
        end
    end

endmodule

// File: rtl/nand_phase_timer.sv
`timescale 1ns/1ps
module nand_phase_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nand_cycle_gen.sv
`timescale 1ns/1ps
module nand_cycle_gen
    import nand_cyc_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned FIELD_W  = 4,
    localparam int unsigned TIMING_W = SLOTS_TOTAL * FIELD_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_valid_i,
    output logic                req_ready_o,
    input  logic [1:0]          req_kind_i,
    input  logic [DATA_W-1:0]   req_data_i,
    input  logic [TIMING_W-1:0] timing_i,
    input  logic                ce_force_i,
    output logic                nand_ce_n_o,
    output logic                nand_cle_o,
    output logic                nand_ale_o,
    output logic                nand_we_n_o,
    output logic                nand_re_n_o,
    output logic [DATA_W-1:0]   nand_dq_o,
    output logic                nand_dq_oe_o,
    input  logic [DATA_W-1:0]   nand_dq_i,
    input  logic                nand_rdy_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                done_o,
    output logic                done_rdy_o
);

    // Ready wait is twice the field, so the timer needs one more bit.
    localparam int unsigned CNT_W = FIELD_W + 1;

    typedef struct packed {
        phase_e             phase;
        cyc_kind_e          kind;
        logic [DATA_W-1:0]  data;
        logic [FIELD_W-1:0] width;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] delay;
        logic [DATA_W-1:0]  rd_data;
        logic               rdy;
        logic               done;
        logic               ce_n;
    } state_t;

    state_t st_d, st_q;

    cyc_kind_e          req_kind;
    logic [FIELD_W-1:0] sel_setup, sel_width, sel_hold, sel_delay;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_zero;
    logic [CNT_W-1:0]   wait_load;

    assign req_kind  = cyc_kind_e'(req_kind_i);
    assign wait_load = {st_q.delay, 1'b0} - 1'b1;

    nand_timing_sel #(
        .FIELD_W (FIELD_W)
    ) i_sel (
        .timing_i  (timing_i),
        .is_read_i (kind_is_read(req_kind)),
        .setup_o   (sel_setup),
        .width_o   (sel_width),
        .hold_o    (sel_hold),
        .delay_o   (sel_delay)
    );

    nand_phase_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.ce_n = ~ce_force_i;
        tmr_load  = 1'b0;
        tmr_val   = '0;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid_i) begin
                    st_d.kind  = req_kind;
                    st_d.data  = req_data_i;
                    st_d.width = sel_width;
                    st_d.hold  = sel_hold;
                    st_d.delay = sel_delay;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(sel_setup);
                    st_d.phase = PH_SETUP;
                end
            end
            PH_SETUP: begin
                if (tmr_zero) begin
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(st_q.width);
                    st_d.phase = PH_PULSE;
                end
            end
            PH_PULSE: begin
                if (tmr_zero) begin
                    if (kind_is_read(st_q.kind)) begin
                        st_d.rd_data = nand_dq_i;
                    end
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(st_q.hold);
                    st_d.phase = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (tmr_zero) begin
                    if (st_q.delay == '0) begin
                        st_d.phase = PH_SAMPLE;
                    end else begin
                        tmr_load   = 1'b1;
                        tmr_val    = wait_load;
                        st_d.phase = PH_WAIT;
                    end
                end
            end
            PH_WAIT: begin
                if (tmr_zero) begin
                    st_d.phase = PH_SAMPLE;
                end
            end
            PH_SAMPLE: begin
                st_d.rdy   = nand_rdy_i;
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.kind  <= KIND_CMD;
            st_q.ce_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    logic in_cycle;
    logic is_rd;

    assign in_cycle = phase_active(st_q.phase);
    assign is_rd    = kind_is_read(st_q.kind);

    assign req_ready_o  = (st_q.phase == PH_IDLE);
    assign nand_ce_n_o  = st_q.ce_n;
    assign nand_cle_o   = in_cycle && (st_q.kind == KIND_CMD);
    assign nand_ale_o   = in_cycle && (st_q.kind == KIND_ADDR);
    assign nand_we_n_o  = !((st_q.phase == PH_PULSE) && !is_rd);
    assign nand_re_n_o  = !((st_q.phase == PH_PULSE) && is_rd);
    assign nand_dq_o    = st_q.data;
    assign nand_dq_oe_o = in_cycle && !is_rd;
    assign rd_data_o    = st_q.rd_data;
    assign done_o       = st_q.done;
    assign done_rdy_o   = st_q.rdy;

endmodule

// File: rtl/nand_cycle_gen_chk.sv
`timescale 1ns/1ps
module nand_cycle_gen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic req_ready_o,
    input logic ce_force_i,
    input logic nand_ce_n_o,
    input logic nand_cle_o,
    input logic nand_ale_o,
    input logic nand_we_n_o,
    input logic nand_re_n_o,
    input logic nand_dq_oe_o,
    input logic done_o
);

    logic live_q;

    always_ff @(posedge clk_i) begin
        live_q <= rst_ni;
    end

    p_one_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!nand_we_n_o && !nand_re_n_o));

    p_latch_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(nand_cle_o && nand_ale_o));

    p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> (nand_we_n_o && nand_re_n_o && !nand_cle_o && !nand_ale_o));

    p_pulse_after_setup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(nand_we_n_o) |-> $past(nand_dq_oe_o));

    p_busy_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!nand_we_n_o || !nand_re_n_o) |-> !req_ready_o);

    p_read_no_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !nand_re_n_o |-> !nand_dq_oe_o);

    p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> req_ready_o);

    p_ce_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q |-> (nand_ce_n_o == !$past(ce_force_i)));

endmodule

bind nand_cycle_gen nand_cycle_gen_chk i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_ready_o  (req_ready_o),
    .ce_force_i   (ce_force_i),
    .nand_ce_n_o  (nand_ce_n_o),
    .nand_cle_o   (nand_cle_o),
    .nand_ale_o   (nand_ale_o),
    .nand_we_n_o  (nand_we_n_o),
    .nand_re_n_o  (nand_re_n_o),
    .nand_dq_oe_o (nand_dq_oe_o),
    .done_o       (done_o)
);

// File: tb/test_nand_cycle_gen.sv
`timescale 1ns/1ps
module test_nand_cycle_gen;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [1:0]  req_kind_i = 2'b00;
    logic [7:0]  req_data_i = 8'h00;
    logic [31:0] timing_i = 32'h0;
    logic        ce_force_i = 1'b0;
    logic        nand_ce_n_o, nand_cle_o, nand_ale_o, nand_we_n_o, nand_re_n_o;
    logic [7:0]  nand_dq_o;
    logic        nand_dq_oe_o;
    logic [7:0]  nand_dq_i = 8'h00;
    logic        nand_rdy_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        done_o, done_rdy_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #2 clk_i = ~clk_i;

    nand_cycle_gen i_nand_cycle_gen (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_valid_i  (req_valid_i),
        .req_ready_o  (req_ready_o),
        .req_kind_i   (req_kind_i),
        .req_data_i   (req_data_i),
        .timing_i     (timing_i),
        .ce_force_i   (ce_force_i),
        .nand_ce_n_o  (nand_ce_n_o),
        .nand_cle_o   (nand_cle_o),
        .nand_ale_o   (nand_ale_o),
        .nand_we_n_o  (nand_we_n_o),
        .nand_re_n_o  (nand_re_n_o),
        .nand_dq_o    (nand_dq_o),
        .nand_dq_oe_o (nand_dq_oe_o),
        .nand_dq_i    (nand_dq_i),
        .nand_rdy_i   (nand_rdy_i),
        .rd_data_o    (rd_data_o),
        .done_o       (done_o),
        .done_rdy_o   (done_rdy_o)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  data;
        logic [31:0] timing;
        logic        rdy;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 8'h70, 32'h0000_0000, 1'b1},
        '{2'd1, 8'h3C, 32'h1234_0000, 1'b0},
        '{2'd2, 8'hA5, 32'hF2A1_0000, 1'b1},
        '{2'd3, 8'h5A, 32'h0000_3521, 1'b1},
        '{2'd3, 8'hC3, 32'hFFFF_0000, 1'b0},
        '{2'd0, 8'hFF, 32'h0000_FFFF, 1'b1},
        '{2'd2, 8'h00, 32'hFFFF_FFFF, 1'b0},
        '{2'd3, 8'h81, 32'hFFFF_FFFF, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk_i) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    // Runs one request; when busy_poke is set a conflicting request is held during the cycle.
    task automatic run_vec(input vec_t v, input bit busy_poke, input int idx);
        bit is_rd;
        int base, s, h, w, dl, he, ps, pe, samp, total;
        int k, n_pre, n_pulse, seen_low, latch_err, oe_err, rdy_err, wrong_strobe;
        is_rd = (v.kind == 2'd3);
        base  = is_rd ? 0 : 16;
        s  = int'(v.timing[base    +: 4]);
        h  = int'(v.timing[base+4  +: 4]);
        w  = int'(v.timing[base+8  +: 4]);
        dl = int'(v.timing[base+12 +: 4]);
        ps = s + 2;
        pe = s + w + 2;
        he = s + w + h + 3;
        samp  = he + 2 * dl + 1;
        total = samp + 1;
        n_pre = 0; n_pulse = 0; seen_low = 0;
        latch_err = 0; oe_err = 0; rdy_err = 0; wrong_strobe = 0;

        @(negedge clk_i);
        req_valid_i = 1'b1;
        req_kind_i  = v.kind;
        req_data_i  = v.data;
        timing_i    = v.timing;
        chk(req_ready_o == 1'b1, "R2", $sformatf("vec%0d ready before accept", idx),
            int'(req_ready_o), 1);
        @(posedge clk_i);
        k = 0;
        forever begin
            @(negedge clk_i);
            k++;
            if (k == 1) begin
                if (busy_poke) begin
                    req_kind_i = v.kind ^ 2'b01;
                    req_data_i = ~v.data;
                    timing_i   = 32'h0;
                end else begin
                    req_valid_i = 1'b0;
                end
            end
            nand_dq_i  = (k == pe) ? v.data : ~v.data;
            nand_rdy_i = (k == samp) ? v.rdy : !v.rdy;
            if (done_o || k > 300) break;
            if (req_ready_o) rdy_err++;
            if (!nand_we_n_o || !nand_re_n_o) begin
                seen_low = 1;
                n_pulse++;
                if (is_rd ? !nand_we_n_o : !nand_re_n_o) wrong_strobe++;
            end else if (!seen_low) begin
                n_pre++;
            end
            if (k <= he) begin
                if (nand_cle_o != (v.kind == 2'd0) || nand_ale_o != (v.kind == 2'd1)) latch_err++;
                if (nand_dq_oe_o != !is_rd) oe_err++;
                if (!is_rd && nand_dq_o != v.data) oe_err++;
            end else begin
                if (nand_cle_o || nand_ale_o || nand_dq_oe_o) latch_err++;
            end
        end
        req_valid_i = 1'b0;

        chk(n_pre == s + 1, "R3", $sformatf("vec%0d setup clocks", idx), n_pre, s + 1);
        chk(n_pulse == w + 1 && wrong_strobe == 0, "R4",
            $sformatf("vec%0d pulse clocks", idx), n_pulse, w + 1);
        chk(latch_err == 0, "R6", $sformatf("vec%0d latch line errors", idx), latch_err, 0);
        chk(oe_err == 0, "R7", $sformatf("vec%0d bus drive errors", idx), oe_err, 0);
        chk(k == total, "R5", $sformatf("vec%0d clocks to done (hold+wait)", idx), k, total);
        chk(done_o && done_rdy_o == v.rdy, "R9", $sformatf("vec%0d sampled ready", idx),
            int'(done_rdy_o), int'(v.rdy));
        chk(rdy_err == 0, "R11", $sformatf("vec%0d ready while busy", idx), rdy_err, 0);
        if (is_rd) begin
            chk(rd_data_o == v.data, "R8", $sformatf("vec%0d read byte", idx),
                int'(rd_data_o), int'(v.data));
        end
        @(negedge clk_i);
        chk(!done_o && req_ready_o, "R9", $sformatf("vec%0d done single pulse", idx),
            int'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        // R1: idle outputs during reset
        chk(req_ready_o && !done_o && nand_we_n_o && nand_re_n_o && !nand_cle_o &&
            !nand_ale_o && !nand_dq_oe_o && nand_ce_n_o, "R1", "outputs in reset",
            {req_ready_o, done_o, nand_we_n_o, nand_re_n_o, nand_cle_o, nand_ale_o,
             nand_dq_oe_o, nand_ce_n_o}, 8'b1011_0001);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk(req_ready_o && nand_ce_n_o && nand_we_n_o, "R1", "outputs after reset",
            {req_ready_o, nand_ce_n_o, nand_we_n_o}, 3'b111);

        // Table walk; odd entries hold a conflicting request while busy (R11)
        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], i[0], i);
        end

        // R10: chip enable follows the force input one clock later
        @(negedge clk_i);
        ce_force_i = 1'b1;
        chk(nand_ce_n_o == 1'b1, "R10", "ce before edge", int'(nand_ce_n_o), 1);
        @(negedge clk_i);
        chk(nand_ce_n_o == 1'b0, "R10", "ce forced", int'(nand_ce_n_o), 0);
        run_vec('{2'd1, 8'h12, 32'h0101_0000, 1'b1}, 1'b0, 100);
        chk(nand_ce_n_o == 1'b0, "R10", "ce held through cycle", int'(nand_ce_n_o), 0);
        ce_force_i = 1'b0;
        @(negedge clk_i);
        chk(nand_ce_n_o == 1'b1, "R10", "ce released", int'(nand_ce_n_o), 1);

        // R2: no request accepted while valid is low
        repeat (4) @(negedge clk_i);
        chk(req_ready_o && nand_we_n_o && !nand_cle_o, "R2", "no start without valid",
            int'(req_ready_o), 1);

        // R3: timing word changed after acceptance does not alter the running cycle
        run_vec('{2'd2, 8'h6E, 32'h0312_0000, 1'b0}, 1'b1, 101);

        // R1: reset in the middle of a cycle returns to idle
        @(negedge clk_i);
        req_valid_i = 1'b1; req_kind_i = 2'd0; req_data_i = 8'h90; timing_i = 32'hFFFF_FFFF;
        @(negedge clk_i);
        req_valid_i = 1'b0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        chk(req_ready_o && !nand_cle_o && !nand_dq_oe_o && nand_we_n_o, "R1",
            "reset mid cycle", {req_ready_o, nand_cle_o, nand_dq_oe_o}, 3'b100);
        rst_ni = 1'b1;
        run_vec('{2'd3, 8'h27, 32'h0000_1000, 1'b1}, 1'b0, 102);

        summary();
    end

endmodule